// File: doc/BRIEF.md
# Non-Overlap Bridge Gate Driver

This block takes the two PWM legs of one audio channel, a positive leg and a negative leg, and routes them onto four output pins. Two mode bits choose how the pins are used. With dead-time insertion off, the pins feed a resistive load directly: one pin in single-ended use, or two pins in differential use. With dead-time insertion on, each leg is turned into a gate-control pair for a complementary MOSFET half bridge. One pin drives the high-side PMOS gate and one drives the low-side NMOS gate.

Inside a pair, both gate pins follow the inverse of the leg level. The transistor that must switch off does so one clock after the leg changes. The transistor that must switch on waits for a programmable number of clock cycles. During that window neither transistor conducts. If the leg changes back inside the window, the window starts over at its full length. Each pair has its own timer, so the two legs are handled independently.

The mode bits are captured only when the frame strobe is high at a clock edge. A new mapping therefore takes effect on frame boundaries only. Pins that the current mode does not use are driven low.

Top module: `bridge_gate_driver`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released with both legs low, all four pins are 0. The captured mode after reset is direct-load single-ended.
- R2: The mode bits are captured only at a clock edge where frame_strobe is 1. A change of cfg_nonovl or cfg_diff without the strobe leaves the pin mapping unchanged.
- R3: Direct-load single-ended mode (cfg_nonovl=0, cfg_diff=0). pin_out[0] equals leg_pos delayed by one clock. pin_out[3:1] are 0, and leg_neg has no effect on any pin.
- R4: Direct-load differential mode (cfg_nonovl=0, cfg_diff=1). pin_out[0] follows leg_pos and pin_out[2] follows leg_neg, each one clock later. pin_out[1] and pin_out[3] are 0.
- R5: Half-bridge mode (cfg_nonovl=1, cfg_diff=0). pin_out[0] is the PMOS gate, where 0 means conducting. pin_out[1] is the NMOS gate, where 1 means conducting. In steady state both equal the inverse of leg_pos. pin_out[3:2] are 0 and leg_neg has no effect.
- R6: Full-bridge mode (cfg_nonovl=1, cfg_diff=1). pin_out[1:0] are the PMOS/NMOS gates of the positive-leg pair and pin_out[3:2] those of the negative-leg pair. Both pairs use the same encoding as R5.
- R7: In a bridge mode, the transistor being switched off changes its gate one clock after its leg changes.
- R8: With dead_cycles = D > 0, both transistors of a pair are off for exactly D cycles after a leg change. The other transistor then turns on.
- R9: With dead_cycles = 0, both gates of a pair switch together, one clock after the leg changes.
- R10: If a leg changes back while its pair is in the off window, the window restarts at its full length. Both transistors stay off until D cycles after the last change.
- R11: A change on one leg does not alter the gate pins of the other pair.
- R12: In a bridge mode, no pair ever has PMOS and NMOS conducting together, that is, gate pins 0 and 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| leg_pos | input | 1 | Positive PWM leg |
| leg_neg | input | 1 | Negative PWM leg |
| frame_strobe | input | 1 | Frame boundary; mode bits are captured when high |
| cfg_nonovl | input | 1 | 1 = drive MOSFET bridges with dead time, 0 = direct load |
| cfg_diff | input | 1 | 1 = differential (both legs), 0 = single-ended |
| dead_cycles | input | 4 | Dead time in clock cycles, 0 to 15 |
| pin_out | output | 4 | Output pins 0 to 3 |

## Verification
A pair timer that holds a wrong count shows up at the gate pins within D+1 cycles of a leg edge. The off window then ends too early, ends too late, or never ends. A window that ends too early can also put both transistors on at once. A wrong level register shows up one clock after the leg changes, as a pin that follows the leg incorrectly. A mode register that loads without the strobe, or fails to load with it, moves signals onto the wrong pins on the very next cycle.

// File: rtl/bgd_pkg.sv
// Package: shared types and sizing for the bridge gate driver.
// Assumes: two legs per channel, index 0 positive and index 1 negative.
package bgd_pkg;
    localparam int NUM_PAIRS = 2;
    localparam int NUM_PINS  = 2 * NUM_PAIRS;

    typedef struct packed {
        logic nonovl;   // 1: MOSFET gate drive with dead time
        logic diff;     // 1: both legs in use
    } bgd_mode_t;
endpackage

// File: rtl/bgd_mode_reg.sv
// Module: holds the output mapping mode.
// Loads the configuration bits only on a frame strobe, so the mapping
// never changes mid-frame. Resets to direct-load single-ended.
module bgd_mode_reg
    import bgd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  bgd_mode_t mode_in,
    output bgd_mode_t mode_q
);
    // Capture the new mode at frame boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (load) begin
            mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/bgd_pair_timer.sv
// Module: dead-time timer for one complementary pair.
// level is the leg value currently applied, registered one clock after
// the input. all_off marks the window in which neither transistor may
// conduct. Any leg change reloads the window, including a change
// during a running window. A zero dead time gives no window.
module bgd_pair_timer #(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              leg,
    input  logic [DEAD_W-1:0] dead,
    output logic              level,
    output logic              all_off
);
    logic [DEAD_W-1:0] remain;

    // Track the leg and count down the off window after each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            all_off <= 1'b0;
            remain  <= '0;
        end else if (leg != level) begin
            level   <= leg;
            all_off <= (dead != '0);
            remain  <= dead;
        end else if (all_off) begin
            if (remain <= DEAD_W'(1)) begin
                all_off <= 1'b0;
            end
            remain <= remain - DEAD_W'(1);
        end
    end
endmodule

// File: rtl/bgd_pin_map.sv
// Module: maps pair levels and off windows onto the output pins.
// Gate encoding: PMOS gate low = conducting, NMOS gate high = conducting.
// Direct-load modes use the levels as they are. Unused pins are 0.
// Purely combinational; all inputs come from flops.
module bgd_pin_map
    import bgd_pkg::*;
(
    input  bgd_mode_t            mode,
    input  logic [NUM_PAIRS-1:0] level,
    input  logic [NUM_PAIRS-1:0] all_off,
    output logic [NUM_PINS-1:0]  pins
);
    logic [NUM_PAIRS-1:0] p_gate;
    logic [NUM_PAIRS-1:0] n_gate;

    // Derive gate levels for each pair.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_gate
        assign p_gate[g] = ~(level[g] & ~all_off[g]);
        assign n_gate[g] = ~level[g] & ~all_off[g];
    end

    // Select the pin assignment for the captured mode.
    always_comb begin
        pins = '0;
        unique case ({mode.nonovl, mode.diff})
            2'b00: pins[0] = level[0];
            2'b01: begin
                pins[0] = level[0];
                pins[2] = level[1];
            end
            2'b10: begin
                pins[0] = p_gate[0];
                pins[1] = n_gate[0];
            end
            default: begin
                pins[0] = p_gate[0];
                pins[1] = n_gate[0];
                pins[2] = p_gate[1];
                pins[3] = n_gate[1];
            end
        endcase
    end
endmodule

// File: rtl/bridge_gate_driver.sv
// Module: top of the bridge gate driver for one channel.
// Wires the mode register, one dead-time timer per leg, and the pin map.
// Assumes the legs are synchronous to clk.
module bridge_gate_driver
    import bgd_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              leg_pos,
    input  logic              leg_neg,
    input  logic              frame_strobe,
    input  logic              cfg_nonovl,
    input  logic              cfg_diff,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic [3:0]        pin_out
);
    bgd_mode_t            mode_q;
    bgd_mode_t            mode_in;
    logic [NUM_PAIRS-1:0] legs;
    logic [NUM_PAIRS-1:0] level;
    logic [NUM_PAIRS-1:0] all_off;

    assign mode_in = '{nonovl: cfg_nonovl, diff: cfg_diff};
    assign legs    = {leg_neg, leg_pos};

    bgd_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_strobe),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        bgd_pair_timer #(.DEAD_W(DEAD_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .leg     (legs[g]),
            .dead    (dead_cycles),
            .level   (level[g]),
            .all_off (all_off[g])
        );
    end

    bgd_pin_map u_map (
        .mode    (mode_q),
        .level   (level),
        .all_off (all_off),
        .pins    (pin_out)
    );
endmodule

// File: rtl/bgd_checker.sv
// Module: assertion checker bound to bridge_gate_driver.
// Watches the pins against the legs and the captured mode.
module bgd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       leg_pos,
    input logic       leg_neg,
    input logic       frame_strobe,
    input logic       mode_nonovl,
    input logic       mode_diff,
    input logic [3:0] pin_out
);
    // R1: pins are low the cycle after a reset edge.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == 4'b0000));

    // R2: mode only moves after a strobe.
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_strobe) |-> ($stable(mode_nonovl) && $stable(mode_diff)));

    // R3: direct single-ended uses pin 0 only, one clock behind the leg.
    p_dac_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !mode_nonovl && !mode_diff)
        |-> (pin_out[3:1] == 3'b000 && pin_out[0] == $past(leg_pos)));

    // R12: never both transistors of a pair conducting.
    p_no_shoot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_nonovl |-> (!(pin_out[0] == 1'b0 && pin_out[1] == 1'b1) &&
                         !(pin_out[2] == 1'b0 && pin_out[3] == 1'b1)));

    // R7: a rising positive leg turns its NMOS off one clock later.
    p_pos_off_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && mode_nonovl &&
         $past(leg_pos) && !$past(leg_pos, 2)) |-> (pin_out[1] == 1'b0));

    // R7: a rising negative leg turns its NMOS off one clock later.
    p_neg_off_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && mode_nonovl && mode_diff &&
         $past(leg_neg) && !$past(leg_neg, 2)) |-> (pin_out[3] == 1'b0));
endmodule

bind bridge_gate_driver bgd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .leg_pos      (leg_pos),
    .leg_neg      (leg_neg),
    .frame_strobe (frame_strobe),
    .mode_nonovl  (mode_q.nonovl),
    .mode_diff    (mode_q.diff),
    .pin_out      (pin_out)
);

// File: tb/bridge_gate_driver_test.sv
// Bench: directed scenarios, one task each, with checks inside the tasks.
module bridge_gate_driver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       leg_pos = 1'b0;
    logic       leg_neg = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       cfg_nonovl = 1'b0;
    logic       cfg_diff = 1'b0;
    logic [3:0] dead_cycles = 4'd0;
    logic [3:0] pin_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    bridge_gate_driver uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .leg_pos      (leg_pos),
        .leg_neg      (leg_neg),
        .frame_strobe (frame_strobe),
        .cfg_nonovl   (cfg_nonovl),
        .cfg_diff     (cfg_diff),
        .dead_cycles  (dead_cycles),
        .pin_out      (pin_out)
    );

    always #10 clk = ~clk;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        checks++;
        if (pin_out !== exp) begin
            errors++;
            $display("FAIL %s pins=%b expected %b", tag, pin_out, exp);
        end
    endtask

    task automatic set_mode(input bit no, input bit df);
        cfg_nonovl   = no;
        cfg_diff     = df;
        frame_strobe = 1'b1;
        cyc(1);
        frame_strobe = 1'b0;
    endtask

    task automatic t_reset();
        leg_pos = 1'b1; leg_neg = 1'b1;
        cyc(3);
        chk(4'b0000, "R1 in reset");
        leg_pos = 1'b0; leg_neg = 1'b0;
        rst_n = 1'b1;
        cyc(1);
        chk(4'b0000, "R1 after release");
    endtask

    task automatic t_dac_single();
        leg_pos = 1'b1; cyc(1); chk(4'b0001, "R3 pos high");
        leg_neg = 1'b1; cyc(1); chk(4'b0001, "R3 neg ignored");
        leg_pos = 1'b0; cyc(1); chk(4'b0000, "R3 pos low");
        leg_pos = 1'b1; cyc(1);
    endtask

    task automatic t_mode_gate();
        cfg_nonovl = 1'b1; cfg_diff = 1'b1;
        cyc(4);
        chk(4'b0001, "R2 no strobe");
        set_mode(1'b0, 1'b1);
        chk(4'b0101, "R4 after strobe");
        cfg_nonovl = 1'b0; cfg_diff = 1'b0;
        cyc(2);
        chk(4'b0101, "R2 held diff");
    endtask

    task automatic t_dac_diff();
        leg_neg = 1'b0; cyc(1); chk(4'b0001, "R4 neg low");
        leg_pos = 1'b0; leg_neg = 1'b1; cyc(1); chk(4'b0100, "R4 swap");
    endtask

    task automatic t_half();
        dead_cycles = 4'd3;
        leg_pos = 1'b0; leg_neg = 1'b0;
        set_mode(1'b1, 1'b0);
        cyc(5);
        chk(4'b0011, "R5 steady low");
        leg_neg = 1'b1; cyc(1); chk(4'b0011, "R5 neg ignored");
        leg_pos = 1'b1;
        cyc(1); chk(4'b0001, "R7 nmos off at once");
        cyc(2); chk(4'b0001, "R8 still off");
        cyc(1); chk(4'b0000, "R8 pmos on");
        leg_pos = 1'b0;
        cyc(1); chk(4'b0001, "R7 pmos off at once");
        cyc(2); chk(4'b0001, "R8 still off");
        cyc(1); chk(4'b0011, "R8 nmos on");
    endtask

    task automatic t_toggle();
        leg_pos = 1'b1;
        cyc(2); chk(4'b0001, "R10 in window");
        leg_pos = 1'b0;
        cyc(1); chk(4'b0001, "R10 restarted");
        cyc(2); chk(4'b0001, "R10 full window");
        cyc(1); chk(4'b0011, "R10 nmos on");
    endtask

    task automatic t_zero_dead();
        dead_cycles = 4'd0;
        leg_pos = 1'b1; cyc(1); chk(4'b0000, "R9 rise together");
        leg_pos = 1'b0; cyc(1); chk(4'b0011, "R9 fall together");
    endtask

    task automatic t_full();
        dead_cycles = 4'd2;
        leg_pos = 1'b1; leg_neg = 1'b0;
        set_mode(1'b1, 1'b1);
        cyc(4);
        chk(4'b1100, "R6 steady");
        leg_pos = 1'b0;
        cyc(1); chk(4'b1101, "R11 pos off, neg kept");
        cyc(1); chk(4'b1101, "R11 pos window");
        cyc(1); chk(4'b1111, "R6 pos nmos on");
        leg_neg = 1'b1;
        cyc(1); chk(4'b0111, "R11 neg off, pos kept");
        cyc(1); chk(4'b0111, "R11 neg window");
        cyc(1); chk(4'b0011, "R6 neg pmos on");
    endtask

    task automatic t_no_shoot();
        dead_cycles = 4'd1;
        for (int i = 0; i < 12; i++) begin
            leg_pos = i[0];
            leg_neg = i[1];
            cyc(1);
            checks++;
            if ((pin_out[0] == 1'b0 && pin_out[1] == 1'b1) ||
                (pin_out[2] == 1'b0 && pin_out[3] == 1'b1)) begin
                errors++;
                $display("FAIL R12 pins=%b expected no pair with 0/1", pin_out);
            end
        end
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_dac_single();
        t_mode_gate();
        t_dac_diff();
        t_half();
        t_toggle();
        t_zero_dead();
        t_full();
        t_no_shoot();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule